// File: doc/BRIEF.md
# Timing Module Interrupt Register Bank

This block is the software-facing control and interrupt front end of a timing distribution module. A 16-bit register bus with byte offsets reaches a control register, a mode register, an active-low interrupt mask, a trigger-channel capture register, a clear-on-read interrupt status register and a row of write-only command addresses that each produce a one-cycle strobe.

Eight interrupt causes feed the status register: trigger, event, un-inhibit, inhibit, error alarm, clock error, setup and stop. Each cause comes from a local input in master mode or from the matching flag of an already decoded upstream message in relay mode. Trigger, setup and stop causes pass only while the input-enable control bit is set. A status bit is set by the rising edge of its cause and stays set until software reads the status register. A single level interrupt request combines the status bits, the mask and the global enable.

Top module: `tmod_irq_bank`

## Requirements
- R1: After reset the control, mode, trigger and status registers read 0x0000, the mask register reads 0x00FF (every cause masked), `irq` is 0 and `cmd_pulse` is 0.
- R2: The control register at offset 0x00 stores bits 3:0 (bit 0 relay mode, bit 1 global interrupt enable, bit 2 external clock select, bit 3 input enable); bits 15:4 read as zero; `ctrl_relay` shows bit 0 and `clk_ext_sel` shows bit 2.
- R3: The mode register at offset 0x02 stores bits 3:0 (bit n selects Mode n), reads them back with bits 15:4 zero, and drives `mode_sel`.
- R4: The mask register at offset 0x04 holds 8 bits, active low: a 0 in bit n lets status bit n request an interrupt; bits 15:8 read as zero.
- R5: Status bit order is 0 trigger, 1 event, 2 un-inhibit, 3 inhibit, 4 error alarm, 5 clock error, 6 setup, 7 stop; `src_misc` bit k feeds status bit k+1. A rising edge on a cause sets its status bit at that clock edge, and the bit stays set until cleared.
- R6: A read of offset 0x08 returns the status in bits 7:0 and clears it at the end of the read cycle; a cause rising in that same cycle leaves its bit set; writes to 0x08 have no effect.
- R7: The trigger register at offset 0x06 sets bit n when trigger channel n+1 rises; any write to 0x06 clears it, except for a channel rising in that same cycle.
- R8: While control bit 3 is 0, rising trigger, setup and stop causes set neither status bits 0, 6, 7 nor trigger register bits; the other causes are unaffected.
- R9: In relay mode (control bit 0 = 1) the causes come from `up_trig`/`up_misc` and the local inputs are ignored; in master mode the reverse.
- R10: `irq` is 1 exactly when control bit 1 is 1 and some status bit is 1 whose mask bit is 0.
- R11: A write to offset 0x14 + 2k (k = 0..6: manual trigger, event, inhibit, un-inhibit, setup, stop, phase reset) raises `cmd_pulse[k]` for exactly the one cycle after the write.
- R12: Reads of the write-only command offsets and of any unmapped offset return 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (6) | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | DATA_W (16) | Write data |
| bus_rdata | output | DATA_W (16) | Read data for `bus_addr`, combinational |
| loc_trig | input | NUM_CH (8) | Local trigger channel inputs |
| loc_misc | input | 7 | Local causes: event, un-inhibit, inhibit, error, clock error, setup, stop |
| up_trig | input | NUM_CH (8) | Upstream trigger-channel message flags |
| up_misc | input | 7 | Upstream message flags, same order as `loc_misc` |
| irq | output | 1 | Interrupt request, level |
| ctrl_relay | output | 1 | Relay mode selected |
| clk_ext_sel | output | 1 | External clock selected |
| mode_sel | output | 4 | Mode register contents |
| cmd_pulse | output | 7 | One-cycle command strobes |

## Verification
The bench builds the block with its defaults: eight trigger channels, a 16-bit bus, a 6-bit offset and registered command strobes. With all eight channels present every trigger register bit and the channel-to-status OR are observable, and the 6-bit offset reaches the last command address and the unmapped offsets above it. A behavioural reference model is compared every cycle on read data, `irq`, strobes and control outputs, while directed sequences exercise masking, input gating, relay switching and clears colliding with new events.

// File: rtl/tmod_irq_pkg.sv
package tmod_irq_pkg;
   localparam int NUM_SRC  = 8;
   localparam int NUM_MISC = 7;
   localparam int NUM_CMD  = 7;

   localparam int OFS_CTRL = 'h00;
   localparam int OFS_MODE = 'h02;
   localparam int OFS_MASK = 'h04;
   localparam int OFS_TRIG = 'h06;
   localparam int OFS_STAT = 'h08;
   localparam int OFS_CMD0 = 'h14;

   localparam int CB_RELAY = 0;
   localparam int CB_IE    = 1;
   localparam int CB_EXTCK = 2;
   localparam int CB_INEN  = 3;

   // misc causes gated by input enable: setup (5) and stop (6)
   localparam logic [NUM_MISC-1:0] MISC_GATED = 7'b110_0000;
endpackage

// File: rtl/tmod_src_select.sv
module tmod_src_select
   import tmod_irq_pkg::*;
#(
   parameter int NUM_CH = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                relay,
   input  logic                inen,
   input  logic [NUM_CH-1:0]   loc_trig,
   input  logic [NUM_MISC-1:0] loc_misc,
   input  logic [NUM_CH-1:0]   up_trig,
   input  logic [NUM_MISC-1:0] up_misc,
   output logic [NUM_CH-1:0]   trig_hit,
   output logic [NUM_SRC-1:0]  src_set
);
   logic [NUM_CH-1:0]   trig_sel, trig_prev, trig_rise;
   logic [NUM_MISC-1:0] misc_sel, misc_prev, misc_rise, misc_set;

   assign trig_sel = relay ? up_trig : loc_trig;
   assign misc_sel = relay ? up_misc : loc_misc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig_prev <= '0;
         misc_prev <= '0;
      end else begin
         trig_prev <= trig_sel;
         misc_prev <= misc_sel;
      end
   end

   assign trig_rise = trig_sel & ~trig_prev;
   assign misc_rise = misc_sel & ~misc_prev;
   assign trig_hit  = inen ? trig_rise : '0;

   for (genvar i = 0; i < NUM_MISC; i++) begin : g_misc
      if (MISC_GATED[i]) begin : g_gated
         assign misc_set[i] = misc_rise[i] & inen;
      end else begin : g_free
         assign misc_set[i] = misc_rise[i];
      end
   end

   assign src_set = {misc_set, |trig_hit};
endmodule

// File: rtl/tmod_reg_file.sv
module tmod_reg_file
   import tmod_irq_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int ADDR_W  = 6,
   parameter int NUM_CH  = 8,
   parameter bit CMD_REG = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic [NUM_SRC-1:0] stat_q,
   input  logic [NUM_CH-1:0]  trig_hit,
   output logic [3:0]         ctrl_q,
   output logic [3:0]         mode_q,
   output logic [NUM_SRC-1:0] mask_q,
   output logic [7:0]         trig_q,
   output logic               stat_clr,
   output logic               trig_clr,
   output logic [NUM_CMD-1:0] cmd_pulse
);
   logic              sel_ctrl, sel_mode, sel_mask, sel_trig, sel_stat;
   logic [7:0]        hit8;
   logic [7:0]        rbyte;
   logic [NUM_CMD-1:0] cmd_hit;

   assign sel_ctrl = bus_addr == ADDR_W'(OFS_CTRL);
   assign sel_mode = bus_addr == ADDR_W'(OFS_MODE);
   assign sel_mask = bus_addr == ADDR_W'(OFS_MASK);
   assign sel_trig = bus_addr == ADDR_W'(OFS_TRIG);
   assign sel_stat = bus_addr == ADDR_W'(OFS_STAT);

   assign stat_clr = bus_rd & sel_stat;
   assign trig_clr = bus_wr & sel_trig;
   assign hit8     = 8'(trig_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         mode_q <= '0;
         mask_q <= '1;
         trig_q <= '0;
      end else begin
         if (bus_wr && sel_ctrl) ctrl_q <= bus_wdata[3:0];
         if (bus_wr && sel_mode) mode_q <= bus_wdata[3:0];
         if (bus_wr && sel_mask) mask_q <= bus_wdata[NUM_SRC-1:0];
         trig_q <= (trig_clr ? 8'h00 : trig_q) | hit8;
      end
   end

   for (genvar k = 0; k < NUM_CMD; k++) begin : g_cmd
      assign cmd_hit[k] = bus_wr && (bus_addr == ADDR_W'(OFS_CMD0 + 2 * k));
   end

   if (CMD_REG) begin : g_cmd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cmd_pulse <= '0;
         else        cmd_pulse <= cmd_hit;
      end
   end else begin : g_cmd_comb
      assign cmd_pulse = cmd_hit;
   end

   always_comb begin
      rbyte = 8'h00;
      if (sel_ctrl) rbyte = {4'h0, ctrl_q};
      if (sel_mode) rbyte = {4'h0, mode_q};
      if (sel_mask) rbyte = mask_q;
      if (sel_trig) rbyte = trig_q;
      if (sel_stat) rbyte = stat_q;
   end

   assign bus_rdata = DATA_W'(rbyte);
endmodule

// File: rtl/tmod_irq_status.sv
module tmod_irq_status
   import tmod_irq_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_set,
   input  logic               stat_clr,
   input  logic [NUM_SRC-1:0] mask_q,
   input  logic               irq_en,
   output logic [NUM_SRC-1:0] stat_q,
   output logic               irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= (stat_clr ? '0 : stat_q) | src_set;
   end

   assign irq = irq_en & (|(stat_q & ~mask_q));
endmodule

// File: rtl/tmod_irq_bank.sv
module tmod_irq_bank
   import tmod_irq_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int ADDR_W  = 6,
   parameter int NUM_CH  = 8,
   parameter bit CMD_REG = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_wr,
   input  logic                bus_rd,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic [NUM_CH-1:0]   loc_trig,
   input  logic [NUM_MISC-1:0] loc_misc,
   input  logic [NUM_CH-1:0]   up_trig,
   input  logic [NUM_MISC-1:0] up_misc,
   output logic                irq,
   output logic                ctrl_relay,
   output logic                clk_ext_sel,
   output logic [3:0]          mode_sel,
   output logic [NUM_CMD-1:0]  cmd_pulse
);
   if (NUM_CH < 1 || NUM_CH > 8) begin : g_bad_ch
      $error("tmod_irq_bank: NUM_CH must be 1..8");
   end
   if (DATA_W < 8) begin : g_bad_dw
      $error("tmod_irq_bank: DATA_W must be at least 8");
   end
   if (ADDR_W < 6) begin : g_bad_aw
      $error("tmod_irq_bank: ADDR_W must reach offset 0x20");
   end

   logic [3:0]         ctrl_q, mode_q;
   logic [NUM_SRC-1:0] mask_q, stat_q, src_set;
   logic [7:0]         trig_q;
   logic [NUM_CH-1:0]  trig_hit;
   logic               stat_clr, trig_clr;

   tmod_src_select #(.NUM_CH(NUM_CH)) u_src (
      .clk(clk), .rst_n(rst_n),
      .relay(ctrl_q[CB_RELAY]), .inen(ctrl_q[CB_INEN]),
      .loc_trig(loc_trig), .loc_misc(loc_misc),
      .up_trig(up_trig), .up_misc(up_misc),
      .trig_hit(trig_hit), .src_set(src_set)
   );

   tmod_reg_file #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .CMD_REG(CMD_REG)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .stat_q(stat_q), .trig_hit(trig_hit),
      .ctrl_q(ctrl_q), .mode_q(mode_q), .mask_q(mask_q), .trig_q(trig_q),
      .stat_clr(stat_clr), .trig_clr(trig_clr), .cmd_pulse(cmd_pulse)
   );

   tmod_irq_status u_stat (
      .clk(clk), .rst_n(rst_n),
      .src_set(src_set), .stat_clr(stat_clr), .mask_q(mask_q),
      .irq_en(ctrl_q[CB_IE]), .stat_q(stat_q), .irq(irq)
   );

   assign ctrl_relay  = ctrl_q[CB_RELAY];
   assign clk_ext_sel = ctrl_q[CB_EXTCK];
   assign mode_sel    = mode_q;
endmodule

// File: rtl/tmod_irq_bank_chk.sv
module tmod_irq_bank_chk #(
   parameter int NUM_CH = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [3:0]        ctrl_q,
   input logic [7:0]        src_set,
   input logic [7:0]        stat_q,
   input logic [7:0]        trig_q,
   input logic [NUM_CH-1:0] trig_hit,
   input logic              stat_clr,
   input logic              trig_clr,
   input logic              irq,
   input logic [6:0]        cmd_pulse
);
   AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q[1] |-> !irq);                                            // R10
   AST_STAT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_clr && src_set == 8'h00) |=> stat_q == 8'h00);            // R6
   AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_clr |=> ((stat_q & $past(stat_q)) == $past(stat_q)));     // R5
   AST_TRIG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_clr && trig_hit == '0) |=> trig_q == 8'h00);              // R7
   AST_INPUT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q[3] |-> ((src_set & 8'hC1) == 8'h00));                   // R8
   AST_CMD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cmd_pulse));                                            // R11
endmodule

bind tmod_irq_bank tmod_irq_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk(clk), .rst_n(rst_n), .ctrl_q(ctrl_q), .src_set(src_set),
   .stat_q(stat_q), .trig_q(trig_q), .trig_hit(trig_hit),
   .stat_clr(stat_clr), .trig_clr(trig_clr), .irq(irq), .cmd_pulse(cmd_pulse)
);

// File: tb/tb_tmod_irq_bank.sv
`timescale 1ns/1ps
module tb_tmod_irq_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [7:0]  loc_trig = '0, up_trig = '0;
   logic [6:0]  loc_misc = '0, up_misc = '0;
   logic        irq, ctrl_relay, clk_ext_sel;
   logic [3:0]  mode_sel;
   logic [6:0]  cmd_pulse;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   tmod_irq_bank dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .loc_trig(loc_trig), .loc_misc(loc_misc),
      .up_trig(up_trig), .up_misc(up_misc), .irq(irq), .ctrl_relay(ctrl_relay),
      .clk_ext_sel(clk_ext_sel), .mode_sel(mode_sel), .cmd_pulse(cmd_pulse)
   );

   // behavioural reference model
   bit [3:0] m_ctrl, m_mode;
   bit [7:0] m_mask = 8'hFF, m_trig, m_stat, m_ptrig;
   bit [6:0] m_pmisc, m_cmd;

   always @(posedge clk) begin
      bit [7:0] st, ed;
      bit [6:0] sm, em;
      bit       en;
      if (!rst_n) begin
         m_ctrl = 0; m_mode = 0; m_mask = 8'hFF; m_trig = 0; m_stat = 0;
         m_ptrig = 0; m_pmisc = 0; m_cmd = 0;
      end else begin
         en = m_ctrl[3];
         st = m_ctrl[0] ? up_trig : loc_trig;
         sm = m_ctrl[0] ? up_misc : loc_misc;
         ed = en ? (st & ~m_ptrig) : 8'h00;
         em = sm & ~m_pmisc;
         if (!en) em[6:5] = 2'b00;
         m_ptrig = st; m_pmisc = sm;
         m_stat = ((bus_rd && bus_addr == 6'h08) ? 8'h00 : m_stat) | {em, |ed};
         m_trig = ((bus_wr && bus_addr == 6'h06) ? 8'h00 : m_trig) | ed;
         m_cmd = 0;
         if (bus_wr) begin
            case (bus_addr)
               6'h00: m_ctrl = bus_wdata[3:0];
               6'h02: m_mode = bus_wdata[3:0];
               6'h04: m_mask = bus_wdata[7:0];
               default: ;
            endcase
            for (int k = 0; k < 7; k++) if (bus_addr == 6'(8'h14 + 2 * k)) m_cmd[k] = 1'b1;
         end
      end
   end

   function automatic bit [15:0] m_read(bit [5:0] a);
      case (a)
         6'h00: return {12'h0, m_ctrl};
         6'h02: return {12'h0, m_mode};
         6'h04: return {8'h0, m_mask};
         6'h06: return {8'h0, m_trig};
         6'h08: return {8'h0, m_stat};
         default: return 16'h0000;
      endcase
   endfunction

   task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // every-cycle comparison against the model
   always @(negedge clk) if (rst_n) begin
      chk("R12/R6 model rdata", bus_rdata, m_read(bus_addr));
      chk("R10 model irq", {15'h0, irq}, {15'h0, m_ctrl[1] && ((m_stat & ~m_mask) != 0)});
      chk("R11 model cmd_pulse", {9'h0, cmd_pulse}, {9'h0, m_cmd});
      chk("R2 model ctrl outputs", {14'h0, ctrl_relay, clk_ext_sel}, {14'h0, m_ctrl[0], m_ctrl[2]});
      chk("R3 model mode_sel", {12'h0, mode_sel}, {12'h0, m_mode});
   end

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic wr(bit [5:0] a, bit [15:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      tick();
      bus_wr = 1'b0;
   endtask

   task automatic rd(bit [5:0] a, output logic [15:0] v);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk); v = bus_rdata;
      tick();
      bus_rd = 1'b0;
   endtask

   task automatic pulse_misc(bit up, int i);
      if (up) up_misc[i] = 1'b1; else loc_misc[i] = 1'b1;
      tick();
      if (up) up_misc[i] = 1'b0; else loc_misc[i] = 1'b0;
      tick();
   endtask

   task automatic pulse_trig(bit up, int i);
      if (up) up_trig[i] = 1'b1; else loc_trig[i] = 1'b1;
      tick();
      if (up) up_trig[i] = 1'b0; else loc_trig[i] = 1'b0;
      tick();
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      #12; rst_n = 1'b1; tick();
      // R1 reset state
      chk("R1 irq", {15'h0, irq}, 16'h0);
      chk("R1 cmd_pulse", {9'h0, cmd_pulse}, 16'h0);
      rd(6'h00, v); chk("R1 ctrl", v, 16'h0000);
      rd(6'h02, v); chk("R1 mode", v, 16'h0000);
      rd(6'h04, v); chk("R1 mask", v, 16'h00FF);
      rd(6'h06, v); chk("R1 trig", v, 16'h0000);
      rd(6'h08, v); chk("R1 status", v, 16'h0000);
      // R2 control fields
      wr(6'h00, 16'hFFFF);
      rd(6'h00, v); chk("R2 ctrl readback", v, 16'h000F);
      chk("R2 relay/extclk", {14'h0, ctrl_relay, clk_ext_sel}, 16'h0003);
      wr(6'h00, 16'h000A);
      chk("R2 relay/extclk low", {14'h0, ctrl_relay, clk_ext_sel}, 16'h0000);
      // R3 mode
      wr(6'h02, 16'hFF04);
      rd(6'h02, v); chk("R3 mode readback", v, 16'h0004);
      chk("R3 mode_sel", {12'h0, mode_sel}, 16'h0004);
      // R4 mask, R5 trigger source, R7 channel capture, R10 irq
      wr(6'h04, 16'hFFFE);
      rd(6'h04, v); chk("R4 mask readback", v, 16'h00FE);
      pulse_trig(0, 2);
      chk("R10 irq on enabled trigger", {15'h0, irq}, 16'h0001);
      rd(6'h06, v); chk("R7 trig channel 3", v, 16'h0004);
      rd(6'h08, v); chk("R5 status trigger bit", v, 16'h0001);
      rd(6'h08, v); chk("R6 status cleared", v, 16'h0000);
      chk("R6 irq dropped", {15'h0, irq}, 16'h0000);
      // R4 masked cause sets status without irq
      pulse_misc(0, 0);
      chk("R4 masked event no irq", {15'h0, irq}, 16'h0000);
      rd(6'h08, v); chk("R5 event bit1", v, 16'h0002);
      // R6 clear colliding with a new event; writes to status ignored
      pulse_misc(0, 3);
      wr(6'h08, 16'h0000);
      bus_addr = 6'h08; bus_rd = 1'b1; loc_misc[0] = 1'b1;
      tick();
      bus_rd = 1'b0; loc_misc[0] = 1'b0;
      tick();
      rd(6'h08, v); chk("R6 new event survives clear", v, 16'h0002);
      // R7 write clears trigger register
      wr(6'h06, 16'h1234);
      rd(6'h06, v); chk("R7 trig cleared by write", v, 16'h0000);
      // R8 input enable off
      wr(6'h00, 16'h0002);
      wr(6'h04, 16'h0000);
      pulse_misc(0, 5); pulse_misc(0, 6); pulse_trig(0, 0);
      chk("R8 no irq from gated causes", {15'h0, irq}, 16'h0000);
      rd(6'h06, v); chk("R8 trig not captured", v, 16'h0000);
      rd(6'h08, v); chk("R8 gated status empty", v, 16'h0000);
      pulse_misc(0, 2);
      rd(6'h08, v); chk("R8 inhibit unaffected", v, 16'h0008);
      // R9 relay mode
      wr(6'h00, 16'h000B);
      pulse_misc(0, 1); pulse_trig(0, 4);
      rd(6'h08, v); chk("R9 local ignored in relay", v, 16'h0000);
      pulse_misc(1, 1);
      rd(6'h08, v); chk("R9 upstream un-inhibit", v, 16'h0004);
      pulse_trig(1, 5);
      rd(6'h06, v); chk("R9 upstream trigger ch6", v, 16'h0020);
      pulse_misc(1, 6);
      rd(6'h08, v); chk("R9 trigger+stop status", v, 16'h0081);
      wr(6'h00, 16'h000A);
      pulse_misc(1, 4);
      rd(6'h08, v); chk("R9 upstream ignored in master", v, 16'h0000);
      // R10 irq needs global enable
      wr(6'h00, 16'h0008);
      pulse_misc(0, 4);
      chk("R10 no irq without enable", {15'h0, irq}, 16'h0000);
      wr(6'h00, 16'h000A);
      chk("R10 irq after enable", {15'h0, irq}, 16'h0001);
      rd(6'h08, v); chk("R5 clock error bit5", v, 16'h0020);
      // R11 command strobes
      for (int k = 0; k < 7; k++) begin
         wr(6'(8'h14 + 2 * k), 16'hFFFF);
         chk("R11 strobe high", {9'h0, cmd_pulse}, 16'(1 << k));
         tick();
         chk("R11 strobe one cycle", {9'h0, cmd_pulse}, 16'h0000);
      end
      // R12 write-only and unmapped reads
      rd(6'h14, v); chk("R12 write-only reads zero", v, 16'h0000);
      rd(6'h20, v); chk("R12 phase reset reads zero", v, 16'h0000);
      rd(6'h22, v); chk("R12 unmapped reads zero", v, 16'h0000);
      tick();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule